// File: doc/BRIEF.md
# Buffer Descriptor Ring Engine

This block steps through two circular lists of buffer descriptors, one for
outgoing frames and one for incoming frames, kept in an internal descriptor
memory. Software builds each list through a small port that reaches either
the descriptor memory or a handful of control registers. A descriptor is
handed to the engine by setting its ownership bit, and the engine hands it
back by clearing that bit after writing completion information into the same
word. The payload bytes and the MAC framing are not handled here. The frame
path is modelled as a start/length output towards a transmitter and as
length-plus-status strobes coming back from the transmitter and the receiver.

Each descriptor uses two memory words. Word 0 holds a 16-bit status/control
field in bits 31:16 and a 16-bit byte count in bits 15:0. Word 1 holds the
buffer address, which the engine never changes. Descriptor `i` sits at word
address `2*i`. Each list begins at its own programmable base descriptor. A
descriptor with its wrap bit set sends the engine back to that base.
Processing on a list begins when software writes its activate register, and
it halts at the first descriptor that software still owns.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset both event flags read 0, both active flags read 0, `tx_start` is low and `rx_ready` is low.
- R2: A write to an activate register (register 2 for receive, register 3 for transmit) starts that list only when data bit 24 is 1. A write with bit 24 at 0 leaves the list inactive.
- R3: When the transmit list reaches a descriptor whose word-0 bit 31 (ready) is set, `tx_start` pulses for one cycle. While the engine waits for `tx_done`, `tx_len` shows word-0 bits 15:0 and `tx_crc` shows word-0 bit 26 (append check sequence).
- R4: On `tx_done`, the engine writes back word 0 with bit 31 cleared and `tx_retry` placed in bits 21:18. All other status bits and the byte count are kept.
- R5: When the receive list reaches a descriptor whose word-0 bit 31 (empty) is set, `rx_ready` is high. On `rx_frame`, word 0 becomes bit 31 cleared, bits 30:22 kept, `rx_err` in bits 21:16 and `rx_len` in bits 15:0. Word 1 is not changed.
- R6: After a descriptor whose word-0 bit 29 (wrap) is set, the next descriptor is the list's base. Otherwise the next descriptor is the one that follows.
- R7: A descriptor whose bit 31 is clear stops that list: its active flag (register 5, bit 0 receive, bit 1 transmit) drops, `rx_ready` stays low, and an `rx_frame` strobe received while stopped changes no descriptor and no flag.
- R8: Every completed descriptor sets its list's event flag (register 4, bit 0 receive, bit 1 transmit). Writing 1 to a flag clears it. A completion in the same cycle as the clear leaves the flag set.
- R9: Receive and transmit completions that arrive in the same cycle are both written back correctly, and both event flags are set.
- R10: Writing a base register (register 0 receive, register 1 transmit) sets both the list's base and its current position, so processing starts at that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel_reg | input | 1 | 1 selects the registers, 0 selects the descriptor memory |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe; data is valid in the cycle after the strobe |
| cpu_addr | input | AW | Word address (registers use bits 2:0) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| tx_start | output | 1 | One-cycle pulse: a transmit descriptor has been taken |
| tx_len | output | 16 | Byte count of the held transmit descriptor |
| tx_crc | output | 1 | Append check sequence for the held descriptor |
| tx_done | input | 1 | Transmitter finished the held frame |
| tx_retry | input | 4 | Retry count reported with `tx_done` |
| rx_ready | output | 1 | An empty receive descriptor is held |
| rx_frame | input | 1 | Receiver finished a frame |
| rx_len | input | 16 | Received byte count |
| rx_err | input | 6 | Receive error flags, nonzero means bad frame |

## Verification
A completion on a list can land in the same clock edge as a software write-1-to-clear on that list's event flag. The bench provokes this by raising `rx_frame` on one edge and then writing the clear on the very next edge, which is when the engine's write-back wins memory access. The flag must read 1 afterwards. The other collision puts `rx_frame` and `tx_done` on the same edge. That case is judged by reading back both descriptors and both event flags.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  // word-0 field positions (status in 31:16, byte count in 15:0)
  localparam int OWN_BIT  = 31;
  localparam int WRAP_BIT = 29;
  localparam int CRC_BIT  = 26;
  localparam int CNT_W    = 16;
  localparam int ERR_W    = 6;
  localparam int RETRY_W  = 4;
  localparam int KEY_BIT  = 24;

  // register map
  localparam logic [2:0] REG_RX_BASE = 3'd0;
  localparam logic [2:0] REG_TX_BASE = 3'd1;
  localparam logic [2:0] REG_RX_ACT  = 3'd2;
  localparam logic [2:0] REG_TX_ACT  = 3'd3;
  localparam logic [2:0] REG_EVENT   = 3'd4;
  localparam logic [2:0] REG_ACTIVE  = 3'd5;

  typedef enum logic [2:0] {
    WK_IDLE, WK_FETCH, WK_RDWAIT, WK_HOLD, WK_WB
  } walk_st_e;
endpackage

// File: rtl/bd_desc_ram.sv
module bd_desc_ram #(
  parameter int WORDS = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     a_en,
  input  logic                     a_we,
  input  logic [$clog2(WORDS)-1:0] a_addr,
  input  logic [DW-1:0]            a_wdata,
  output logic [DW-1:0]            a_rdata,
  input  logic                     b_we,
  input  logic [$clog2(WORDS)-1:0] b_addr,
  input  logic [DW-1:0]            b_wdata,
  output logic [DW-1:0]            b_rdata
);
  logic [DW-1:0] mem [WORDS];

  // read-first on both ports; engine write is applied last
  always_ff @(posedge clk) begin
    if (a_en) a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/bd_ring_walker.sv
module bd_ring_walker
  import bd_ring_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_idx,
  input  logic [IW-1:0] base,
  input  logic          act,
  input  logic          gnt,
  input  logic [31:0]   rdata,
  input  logic          ev,
  input  logic [31:0]   wb_word,
  output logic          req,
  output logic          we,
  output logic [IW-1:0] idx,
  output logic [31:0]   word,
  output logic          done,
  output logic          active,
  output logic          hold
);
  walk_st_e st;

  assign req  = (st == WK_FETCH) || (st == WK_WB);
  assign we   = (st == WK_WB);
  assign done = (st == WK_WB) && gnt;
  assign hold = (st == WK_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= WK_IDLE;
      idx    <= '0;
      word   <= '0;
      active <= 1'b0;
    end else begin
      case (st)
        WK_IDLE: if (act) begin
          active <= 1'b1;
          st     <= WK_FETCH;
        end
        WK_FETCH: if (gnt) st <= WK_RDWAIT;
        WK_RDWAIT: if (rdata[OWN_BIT]) begin
          word <= rdata;
          st   <= WK_HOLD;
        end else begin
          active <= 1'b0;
          st     <= WK_IDLE;
        end
        WK_HOLD: if (ev) begin
          word <= wb_word;
          st   <= WK_WB;
        end
        WK_WB: if (gnt) begin
          idx <= word[WRAP_BIT] ? base : idx + 1'b1;
          st  <= WK_FETCH;
        end
        default: st <= WK_IDLE;
      endcase
      if (load) idx <= load_idx;
    end
  end
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
  import bd_ring_pkg::*;
#(
  parameter int DESC_COUNT = 16,
  parameter int AW         = $clog2(DESC_COUNT) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_sel_reg,
  input  logic          cpu_we,
  input  logic          cpu_re,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          tx_start,
  output logic [15:0]   tx_len,
  output logic          tx_crc,
  input  logic          tx_done,
  input  logic [3:0]    tx_retry,
  output logic          rx_ready,
  input  logic          rx_frame,
  input  logic [15:0]   rx_len,
  input  logic [5:0]    rx_err
);
  localparam int IW    = $clog2(DESC_COUNT);
  localparam int WORDS = 2 * DESC_COUNT;
  localparam int RX = 0;
  localparam int TX = 1;

  logic [1:0]    ring_req, ring_we, ring_gnt, ring_done, ring_active, ring_hold;
  logic [1:0]    ring_ld, ring_act, ring_ev;
  logic [IW-1:0] ring_idx  [2];
  logic [IW-1:0] ring_base [2];
  logic [31:0]   ring_word [2];
  logic [31:0]   ring_wb   [2];
  logic [1:0]    ev_q;
  logic          reg_wr, sel_q, tx_hold_q;
  logic [2:0]    raddr;
  logic [31:0]   reg_rd_q, a_rdata, b_rdata, b_wdata;
  logic [IW-1:0] b_idx;
  logic          b_we;

  // ---------------- register port ----------------
  assign reg_wr = cpu_we && cpu_sel_reg;
  assign raddr  = cpu_addr[2:0];

  assign ring_ld[RX]  = reg_wr && (raddr == REG_RX_BASE);
  assign ring_ld[TX]  = reg_wr && (raddr == REG_TX_BASE);
  assign ring_act[RX] = reg_wr && (raddr == REG_RX_ACT) && cpu_wdata[KEY_BIT];
  assign ring_act[TX] = reg_wr && (raddr == REG_TX_ACT) && cpu_wdata[KEY_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base[RX] <= '0;
      ring_base[TX] <= '0;
      ev_q          <= '0;
      sel_q         <= 1'b0;
      reg_rd_q      <= '0;
      tx_hold_q     <= 1'b0;
    end else begin
      if (ring_ld[RX]) ring_base[RX] <= cpu_wdata[IW-1:0];
      if (ring_ld[TX]) ring_base[TX] <= cpu_wdata[IW-1:0];
      // completion has priority over a simultaneous write-1-to-clear
      ev_q <= (ev_q & ~((reg_wr && raddr == REG_EVENT) ? cpu_wdata[1:0] : 2'b00))
              | ring_done;
      tx_hold_q <= ring_hold[TX];
      if (cpu_re) begin
        sel_q <= cpu_sel_reg;
        case (raddr)
          REG_RX_BASE: reg_rd_q <= {{(32-IW){1'b0}}, ring_base[RX]};
          REG_TX_BASE: reg_rd_q <= {{(32-IW){1'b0}}, ring_base[TX]};
          REG_EVENT:   reg_rd_q <= {30'd0, ev_q};
          REG_ACTIVE:  reg_rd_q <= {30'd0, ring_active};
          default:     reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign cpu_rdata = sel_q ? reg_rd_q : a_rdata;

  // ---------------- write-back words ----------------
  assign ring_wb[RX] = {1'b0, ring_word[RX][30:22], rx_err, rx_len};
  assign ring_wb[TX] = {1'b0, ring_word[TX][30:22], tx_retry,
                        ring_word[TX][17:0]};
  assign ring_ev[RX] = rx_frame;
  assign ring_ev[TX] = tx_done;

  // ---------------- list walkers ----------------
  for (genvar r = 0; r < 2; r++) begin : g_ring
    bd_ring_walker #(.IW(IW)) u_walk (
      .clk      (clk),
      .rst      (rst),
      .load     (ring_ld[r]),
      .load_idx (cpu_wdata[IW-1:0]),
      .base     (ring_base[r]),
      .act      (ring_act[r]),
      .gnt      (ring_gnt[r]),
      .rdata    (b_rdata),
      .ev       (ring_ev[r]),
      .wb_word  (ring_wb[r]),
      .req      (ring_req[r]),
      .we       (ring_we[r]),
      .idx      (ring_idx[r]),
      .word     (ring_word[r]),
      .done     (ring_done[r]),
      .active   (ring_active[r]),
      .hold     (ring_hold[r])
    );
  end

  // fixed priority: receive first
  assign ring_gnt[RX] = ring_req[RX];
  assign ring_gnt[TX] = ring_req[TX] && !ring_req[RX];
  assign b_idx   = ring_gnt[TX] ? ring_idx[TX]  : ring_idx[RX];
  assign b_wdata = ring_gnt[TX] ? ring_word[TX] : ring_word[RX];
  assign b_we    = |(ring_gnt & ring_we);

  bd_desc_ram #(.WORDS(WORDS), .DW(32)) u_ram (
    .clk     (clk),
    .a_en    ((cpu_re || cpu_we) && !cpu_sel_reg),
    .a_we    (cpu_we && !cpu_sel_reg),
    .a_addr  (cpu_addr),
    .a_wdata (cpu_wdata),
    .a_rdata (a_rdata),
    .b_we    (b_we),
    .b_addr  ({b_idx, 1'b0}),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

  // ---------------- frame-side outputs ----------------
  assign tx_start = ring_hold[TX] && !tx_hold_q;
  assign tx_len   = ring_word[TX][CNT_W-1:0];
  assign tx_crc   = ring_word[TX][CRC_BIT];
  assign rx_ready = ring_hold[RX];
endmodule

// File: rtl/bd_ring_engine_chk.sv
module bd_ring_engine_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_sel_reg,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [31:0]   cpu_wdata,
  input logic [1:0]    ev,
  input logic [1:0]    act,
  input logic [1:0]    done,
  input logic          tx_start,
  input logic          rx_ready
);
  logic prev_rst = 1'b0;

  always_ff @(posedge clk) begin
    prev_rst <= rst;
    if (prev_rst && !rst)
      assert_reset_idle_R1: assert (ev == 2'b00 && act == 2'b00 && !tx_start && !rx_ready)
        else $error("R1 state not idle after reset");
  end

  assert_tx_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_tx_start_active_R3: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> act[1]);

  assert_rx_ready_active_R7: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> act[0]);

  assert_event_set_R8: assert property (@(posedge clk) disable iff (rst)
    done[0] |=> ev[0]);

  assert_event_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ev[0] && !(cpu_we && cpu_sel_reg && cpu_addr[2:0] == 3'd4 && cpu_wdata[0])) |=> ev[0]);

  assert_single_writeback_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
endmodule

bind bd_ring_engine bd_ring_engine_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_sel_reg (cpu_sel_reg),
  .cpu_we      (cpu_we),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .ev          (ev_q),
  .act         (ring_active),
  .done        (ring_done),
  .tx_start    (tx_start),
  .rx_ready    (rx_ready)
);

// File: tb/bd_ring_engine_test.sv
module bd_ring_engine_test;
  localparam int N  = 16;
  localparam int AW = 5;
  localparam logic [31:0] KEY = 32'h0100_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          cpu_sel_reg = 1'b0, cpu_we = 1'b0, cpu_re = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic [31:0]   cpu_rdata;
  logic          tx_start, tx_crc, rx_ready;
  logic [15:0]   tx_len;
  logic          tx_done = 1'b0, rx_frame = 1'b0;
  logic [3:0]    tx_retry = '0;
  logic [15:0]   rx_len = '0;
  logic [5:0]    rx_err = '0;

  int  checks = 0, fails = 0;
  bit  finished = 1'b0;

  bd_ring_engine #(.DESC_COUNT(N)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, int addr, logic [31:0] data);
    @(negedge clk);
    cpu_sel_reg = sel; cpu_addr = AW'(addr); cpu_wdata = data; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(logic sel, int addr, output logic [31:0] data);
    @(negedge clk);
    cpu_sel_reg = sel; cpu_addr = AW'(addr); cpu_re = 1'b1;
    @(negedge clk);
    cpu_re = 1'b0;
    data = cpu_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tx(string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_start) return;
    end
    chk(req, 32'd0, 32'd1);
  endtask

  task automatic wait_rx(string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rx_ready) return;
    end
    chk(req, 32'd0, 32'd1);
  endtask

  task automatic send_tx_done(logic [3:0] retry);
    @(negedge clk); tx_done = 1'b1; tx_retry = retry;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic send_rx(logic [15:0] len, logic [5:0] err);
    @(negedge clk); rx_frame = 1'b1; rx_len = len; rx_err = err;
    @(negedge clk); rx_frame = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 tx_start", {31'd0, tx_start}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd0);
    rd(1'b1, 4, d); chk("R1 events", d, 32'd0);
    rd(1'b1, 5, d); chk("R1 active", d, 32'd0);
  endtask

  task automatic t_transmit();
    logic [31:0] d;
    wr(1'b1, 1, 32'd4);                       // R10 transmit base = 4
    wr(1'b0, 8,  32'h8C00_0064);              // desc4 ready|last|crc, 100
    wr(1'b0, 10, 32'hA800_003C);              // desc5 ready|wrap|last, 60
    wr(1'b0, 12, 32'h8800_004D);              // desc6 owned but beyond wrap
    wr(1'b1, 3, 32'h0000_0001);               // R2 no key bit
    idle(10);
    rd(1'b1, 5, d); chk("R2 no start without bit24", d, 32'd0);
    wr(1'b1, 3, KEY);
    wait_tx("R3 first tx_start");
    chk("R10 tx_len from base desc", {16'd0, tx_len}, 32'd100);
    chk("R3 tx_crc set", {31'd0, tx_crc}, 32'd1);
    send_tx_done(4'd3);
    wait_tx("R3 second tx_start");
    chk("R3 tx_len second", {16'd0, tx_len}, 32'd60);
    chk("R3 tx_crc clear", {31'd0, tx_crc}, 32'd0);
    send_tx_done(4'hA);
    idle(10);
    rd(1'b1, 5, d); chk("R7 tx stopped at unowned base", d, 32'd0);
    rd(1'b0, 8, d);  chk("R4 desc4 writeback", d, 32'h0C0C_0064);
    rd(1'b0, 10, d); chk("R4 desc5 writeback", d, 32'h2828_003C);
    rd(1'b0, 12, d); chk("R6 desc6 untouched", d, 32'h8800_004D);
    rd(1'b1, 4, d);  chk("R8 tx event set", d, 32'd2);
    wr(1'b1, 4, 32'd2);
    rd(1'b1, 4, d);  chk("R8 tx event cleared", d, 32'd0);
    // position after wrap is the base
    wr(1'b0, 8, 32'hA000_0021);
    wr(1'b1, 3, KEY);
    wait_tx("R6 restart tx_start");
    chk("R6 restart at base", {16'd0, tx_len}, 32'd33);
    send_tx_done(4'd0);
    idle(10);
    wr(1'b1, 4, 32'd2);
  endtask

  task automatic t_receive();
    logic [31:0] d;
    wr(1'b0, 0, 32'h8000_0000);
    wr(1'b0, 1, 32'hDEAD_BEEF);
    wr(1'b0, 2, 32'hA000_0000);
    wr(1'b1, 2, KEY);
    wait_rx("R5 rx_ready first");
    send_rx(16'd64, 6'd0);
    wait_rx("R5 rx_ready second");
    send_rx(16'd1518, 6'h05);
    idle(10);
    rd(1'b0, 0, d); chk("R5 desc0 writeback", d, 32'h0000_0040);
    rd(1'b0, 1, d); chk("R5 buffer word kept", d, 32'hDEAD_BEEF);
    rd(1'b0, 2, d); chk("R5 desc1 writeback errors", d, 32'h2005_05EE);
    rd(1'b1, 5, d); chk("R7 rx stopped", d, 32'd0);
    chk("R7 rx_ready low", {31'd0, rx_ready}, 32'd0);
    rd(1'b1, 4, d); chk("R8 rx event set", d, 32'd1);
    wr(1'b1, 4, 32'd1);
    send_rx(16'd9, 6'd0);
    idle(5);
    rd(1'b0, 0, d); chk("R7 frame ignored desc", d, 32'h0000_0040);
    rd(1'b1, 4, d); chk("R7 frame ignored event", d, 32'd0);
  endtask

  task automatic t_set_beats_clear();
    logic [31:0] d;
    wr(1'b0, 0, 32'hA000_0000);
    wr(1'b1, 2, KEY);
    wait_rx("R8 rx_ready");
    @(negedge clk); rx_frame = 1'b1; rx_len = 16'd10; rx_err = 6'd0;
    @(negedge clk); rx_frame = 1'b0;
    cpu_sel_reg = 1'b1; cpu_addr = AW'(4); cpu_wdata = 32'd1; cpu_we = 1'b1;
    @(negedge clk); cpu_we = 1'b0;
    rd(1'b1, 4, d); chk("R8 set wins over clear", d, 32'd1);
    rd(1'b0, 0, d); chk("R5 single-desc ring writeback", d, 32'h2000_000A);
    wr(1'b1, 4, 32'd1);
    rd(1'b1, 4, d); chk("R8 clear after", d, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(1'b0, 0, 32'hA000_0000);
    wr(1'b0, 8, 32'hA400_00C8);
    wr(1'b1, 3, KEY);
    wait_tx("R9 tx_start");
    wr(1'b1, 2, KEY);
    wait_rx("R9 rx_ready");
    @(negedge clk);
    rx_frame = 1'b1; rx_len = 16'd20; rx_err = 6'd2;
    tx_done  = 1'b1; tx_retry = 4'd1;
    @(negedge clk);
    rx_frame = 1'b0; tx_done = 1'b0;
    idle(10);
    rd(1'b0, 0, d); chk("R9 rx desc", d, 32'h2002_0014);
    rd(1'b0, 8, d); chk("R9 tx desc", d, 32'h2404_00C8);
    rd(1'b1, 4, d); chk("R9 both events", d, 32'd3);
    rd(1'b1, 5, d); chk("R9 both stopped", d, 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_transmit();
    t_receive();
    t_set_beats_clear();
    t_collide();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule